// File: doc/BRIEF.md
# Receive-Threshold Flow-Control Character Injector

This block lives on the transmit path of one serial channel. It watches how full the local receive FIFO is and tells the far end to pause or continue. When the fill count climbs above a programmed high-water mark, the block enters a halted state and places the pause ("off") character or characters into the transmit stream. When the fill count later falls to a programmed low-water mark, the block leaves the halted state and places the continue ("on") character or characters into the stream. The gap between the two marks is the hysteresis band. Inside that band nothing happens.

The block sits between the transmit FIFO and the character shifter. Both of those links use a request/acknowledge byte handshake. The block keeps one output holding register, which stands for the character boundary. An injected character goes into that register ahead of any waiting FIFO byte. A byte already offered to the shifter stays in place until the shifter accepts it. Four character registers set the "on" and "off" pair values. A two-bit select chooses the first of each pair, the second, both in order, or no injection at all. The word-length code trims injected characters to the active frame size.

Top module: `fcinj_top`

## Requirements
- R1: After reset `tx_req` and `fifo_ack` are low. While the fill level stays at or below the high-water mark, the shifter receives no flow-control character.
- R2: The high-water mark is 4 × `thr_cfg[3:0]`. With injection enabled, a fill level strictly above it enters the halted state and issues the off sequence. A level equal to the mark does nothing.
- R3: The low-water mark is 4 × `thr_cfg[7:4]`. In the halted state, a fill level at or below it leaves the halted state and issues the on sequence. A level between the two marks changes nothing.
- R4: `mode_sel` picks the characters. 2'b10 sends the first character of the pair (`xon_a` / `xoff_a`). 2'b01 sends the second (`xon_b` / `xoff_b`). 2'b11 sends first then second, back to back, with no FIFO byte between them.
- R5: Each change of the halted state sends its sequence exactly once. No character repeats while the state holds.
- R6: At a character boundary, a pending flow-control character wins over a requesting FIFO byte. `fifo_ack` stays low in that cycle.
- R7: An offered byte keeps `tx_req` high and `tx_byte` stable until the cycle in which `tx_ack` is high.
- R8: `word_len` codes 2'b00, 2'b01, 2'b10 and 2'b11 mean 5, 6, 7 and 8 data bits. Bits of an injected character above that width are driven as zero. FIFO bytes pass through unchanged.
- R9: With `mode_sel` = 2'b00 the block injects nothing and only forwards FIFO bytes.
- R10: When the holding register is empty or being accepted, and nothing is pending, a requesting FIFO byte gets a one-cycle `fifo_ack` and appears on `tx_byte` from the next cycle. FIFO bytes keep their order.
- R11: If the holding register is empty, an off character is offered two clock edges after the level change that crossed the mark. The first edge samples the level and the second loads the character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | 7 | Receive FIFO fill count, 0 to 64 |
| thr_cfg | input | 8 | [3:0] high-water nibble, [7:4] low-water nibble, each scaled by 4 |
| mode_sel | input | 2 | Injection select: 00 off, 01 second char, 10 first char, 11 both |
| word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| xon_a | input | 8 | First continue character |
| xon_b | input | 8 | Second continue character |
| xoff_a | input | 8 | First pause character |
| xoff_b | input | 8 | Second pause character |
| fifo_req | input | 1 | Transmit FIFO has a byte |
| fifo_byte | input | 8 | Head byte of the transmit FIFO |
| fifo_ack | output | 1 | Head byte taken at this clock edge |
| tx_req | output | 1 | Byte offered to the shifter |
| tx_byte | output | 8 | Offered byte |
| tx_ack | input | 1 | Shifter takes the offered byte at this edge |

## Verification
A halted-state flag stuck at the wrong value shows up on the shifter side within two edges of a threshold crossing: an off or on character is missing, duplicated, or appears inside the hysteresis band. A sequence pointer that fails to advance or clear shows as a lone second character, a repeated first character, or a FIFO byte that slips between the two halves of a pair. Arbitration faults show as reordered or lost FIFO bytes, or as a byte that changes while the shifter has not yet acknowledged it. All of these appear in the accepted byte stream, which the bench compares against its own threshold model.

// File: rtl/fcinj_pkg.sv
package fcinj_pkg;

   localparam int CHAR_W = 8;

   // select encodings (bit order matters: 2'b10 is the first char of a pair)
   localparam logic [1:0] SEL_OFF    = 2'b00;
   localparam logic [1:0] SEL_SECOND = 2'b01;
   localparam logic [1:0] SEL_FIRST  = 2'b10;
   localparam logic [1:0] SEL_BOTH   = 2'b11;

   typedef enum logic [1:0] {
      FCK_NONE  = 2'd0,
      FCK_PAUSE = 2'd1,
      FCK_GO    = 2'd2
   } fc_kind_e;

   // word-length code 0..3 -> 5..8 low bits kept
   function automatic logic [CHAR_W-1:0] frame_mask(input logic [1:0] wl);
      logic [CHAR_W-1:0] m;
      m = '1;
      m = m >> (CHAR_W - 5 - int'(wl));
      return m;
   endfunction

endpackage

// File: rtl/fcinj_lvl.sv
module fcinj_lvl #(
   parameter int LVL_W     = 7,
   parameter int NIB_W     = 4,
   parameter int SCALE     = 4,
   parameter bit REG_LEVEL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [NIB_W-1:0] hi_nib,
   input  logic [NIB_W-1:0] lo_nib,
   output logic             go_halt,
   output logic             go_resume
);

   logic [LVL_W-1:0] lvl;
   logic [LVL_W-1:0] hi_mark;
   logic [LVL_W-1:0] lo_mark;
   logic             halted_q;

   generate
      if (REG_LEVEL) begin : g_lvl_reg
         logic [LVL_W-1:0] lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= '0;
            else        lvl_q <= rx_level;
         end
         assign lvl = lvl_q;
      end else begin : g_lvl_dir
         assign lvl = rx_level;
      end
   endgenerate

   assign hi_mark = LVL_W'(hi_nib) * LVL_W'(SCALE);
   assign lo_mark = LVL_W'(lo_nib) * LVL_W'(SCALE);

   assign go_halt   = en && !halted_q && (lvl >  hi_mark);
   assign go_resume = en &&  halted_q && (lvl <= lo_mark);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         halted_q <= 1'b0;
      else if (!en)       halted_q <= 1'b0;
      else if (go_halt)   halted_q <= 1'b1;
      else if (go_resume) halted_q <= 1'b0;
   end

endmodule

// File: rtl/fcinj_seq.sv
module fcinj_seq
   import fcinj_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        sel,
   input  logic              go_halt,
   input  logic              go_resume,
   input  logic              take,
   input  logic [CHAR_W-1:0] go_a,
   input  logic [CHAR_W-1:0] go_b,
   input  logic [CHAR_W-1:0] pause_a,
   input  logic [CHAR_W-1:0] pause_b,
   output logic              pend,
   output logic [CHAR_W-1:0] pend_char
);

   fc_kind_e kind_q;
   logic     second_q;
   logic     start_second;

   // single-character second-of-pair mode starts on the second slot
   assign start_second = (sel == SEL_SECOND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q   <= FCK_NONE;
         second_q <= 1'b0;
      end else if (sel == SEL_OFF) begin
         kind_q   <= FCK_NONE;
         second_q <= 1'b0;
      end else if (go_halt) begin
         kind_q   <= FCK_PAUSE;
         second_q <= start_second;
      end else if (go_resume) begin
         kind_q   <= FCK_GO;
         second_q <= start_second;
      end else if (take) begin
         if (sel == SEL_BOTH && !second_q) begin
            second_q <= 1'b1;
         end else begin
            kind_q   <= FCK_NONE;
            second_q <= 1'b0;
         end
      end
   end

   assign pend = (kind_q != FCK_NONE);

   always_comb begin
      unique case (kind_q)
         FCK_PAUSE: pend_char = second_q ? pause_b : pause_a;
         FCK_GO:    pend_char = second_q ? go_b    : go_a;
         default:   pend_char = '0;
      endcase
   end

endmodule

// File: rtl/fcinj_arb.sv
module fcinj_arb
   import fcinj_pkg::*;
#(
   parameter bit MASK_FIFO = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fc_pend,
   input  logic [CHAR_W-1:0] fc_char,
   input  logic [1:0]        word_len,
   input  logic              fifo_req,
   input  logic [CHAR_W-1:0] fifo_byte,
   output logic              fifo_ack,
   output logic              fc_take,
   output logic              tx_req,
   output logic [CHAR_W-1:0] tx_byte,
   input  logic              tx_ack,
   output logic              out_fc
);

   logic              hold_v;
   logic [CHAR_W-1:0] hold_b;
   logic              hold_fc;
   logic              slot_free;
   logic [CHAR_W-1:0] mask;
   logic [CHAR_W-1:0] fifo_val;

   assign mask      = frame_mask(word_len);
   assign slot_free = !hold_v || tx_ack;
   assign fc_take   = slot_free && fc_pend;
   assign fifo_ack  = slot_free && !fc_pend && fifo_req;

   generate
      if (MASK_FIFO) begin : g_fifo_trim
         assign fifo_val = fifo_byte & mask;
      end else begin : g_fifo_raw
         assign fifo_val = fifo_byte;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v  <= 1'b0;
         hold_b  <= '0;
         hold_fc <= 1'b0;
      end else if (slot_free) begin
         if (fc_pend) begin
            hold_v  <= 1'b1;
            hold_b  <= fc_char & mask;
            hold_fc <= 1'b1;
         end else if (fifo_req) begin
            hold_v  <= 1'b1;
            hold_b  <= fifo_val;
            hold_fc <= 1'b0;
         end else begin
            hold_v  <= 1'b0;
            hold_fc <= 1'b0;
         end
      end
   end

   assign tx_req  = hold_v;
   assign tx_byte = hold_b;
   assign out_fc  = hold_fc;

endmodule

// File: rtl/fcinj_top.sv
module fcinj_top
   import fcinj_pkg::*;
#(
   parameter int  FIFO_DEPTH = 64,
   parameter int  NIB_W      = 4,
   parameter int  THR_SCALE  = 4,
   parameter bit  REG_LEVEL  = 1'b0,
   parameter bit  MASK_FIFO  = 1'b0,
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [2*NIB_W-1:0] thr_cfg,
   input  logic [1:0]        mode_sel,
   input  logic [1:0]        word_len,
   input  logic [CHAR_W-1:0] xon_a,
   input  logic [CHAR_W-1:0] xon_b,
   input  logic [CHAR_W-1:0] xoff_a,
   input  logic [CHAR_W-1:0] xoff_b,
   input  logic              fifo_req,
   input  logic [CHAR_W-1:0] fifo_byte,
   output logic              fifo_ack,
   output logic              tx_req,
   output logic [CHAR_W-1:0] tx_byte,
   input  logic              tx_ack
);

   localparam int MAX_MARK = THR_SCALE * ((1 << NIB_W) - 1);

   generate
      if (MAX_MARK > FIFO_DEPTH) begin : g_bad_scale
         $error("threshold range exceeds FIFO depth");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO depth too small");
      end
   endgenerate

   logic              inj_en;
   logic              go_halt;
   logic              go_resume;
   logic              fc_pend;
   logic [CHAR_W-1:0] fc_char;
   logic              fc_take;
   logic              out_fc;

   assign inj_en = (mode_sel != SEL_OFF);

   fcinj_lvl #(
      .LVL_W    (LVL_W),
      .NIB_W    (NIB_W),
      .SCALE    (THR_SCALE),
      .REG_LEVEL(REG_LEVEL)
   ) u_lvl (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (inj_en),
      .rx_level (rx_level),
      .hi_nib   (thr_cfg[NIB_W-1:0]),
      .lo_nib   (thr_cfg[2*NIB_W-1:NIB_W]),
      .go_halt  (go_halt),
      .go_resume(go_resume)
   );

   fcinj_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (mode_sel),
      .go_halt  (go_halt),
      .go_resume(go_resume),
      .take     (fc_take),
      .go_a     (xon_a),
      .go_b     (xon_b),
      .pause_a  (xoff_a),
      .pause_b  (xoff_b),
      .pend     (fc_pend),
      .pend_char(fc_char)
   );

   fcinj_arb #(
      .MASK_FIFO(MASK_FIFO)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .fc_pend  (fc_pend),
      .fc_char  (fc_char),
      .word_len (word_len),
      .fifo_req (fifo_req),
      .fifo_byte(fifo_byte),
      .fifo_ack (fifo_ack),
      .fc_take  (fc_take),
      .tx_req   (tx_req),
      .tx_byte  (tx_byte),
      .tx_ack   (tx_ack),
      .out_fc   (out_fc)
   );

endmodule

// File: rtl/fcinj_chk.sv
module fcinj_chk #(
   parameter bit MASK_FIFO = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_sel,
   input logic [1:0] word_len,
   input logic       fifo_req,
   input logic [7:0] fifo_byte,
   input logic       fifo_ack,
   input logic       tx_req,
   input logic [7:0] tx_byte,
   input logic       tx_ack,
   input logic       fc_pend,
   input logic       out_fc
);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_ack) |=> (tx_req && $stable(tx_byte)));

   p_fifo_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ack |-> (fifo_req && (!tx_req || tx_ack)));

   p_fifo_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ack |=> (tx_req && !out_fc && (MASK_FIFO || tx_byte == $past(fifo_byte))));

   p_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ack |-> !fc_pend);

   p_trim_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && out_fc && word_len == 2'b00) |-> (tx_byte[7:5] == 3'b000));

   p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b00) |=> !fc_pend);

   p_idle_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_req && fifo_req && !fc_pend) |-> fifo_ack);

endmodule

bind fcinj_top fcinj_chk #(.MASK_FIFO(MASK_FIFO)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_sel (mode_sel),
   .word_len (word_len),
   .fifo_req (fifo_req),
   .fifo_byte(fifo_byte),
   .fifo_ack (fifo_ack),
   .tx_req   (tx_req),
   .tx_byte  (tx_byte),
   .tx_ack   (tx_ack),
   .fc_pend  (fc_pend),
   .out_fc   (out_fc)
);

// File: tb/sim_fcinj_top.sv
module sim_fcinj_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] ON_A = 8'hD1, ON_B = 8'hA5, OFF_A = 8'hF3, OFF_B = 8'h6C;
   localparam int HI = 32, LO = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] rx_level = '0;
   logic [7:0] thr_cfg = 8'h28;
   logic [1:0] mode_sel = 2'b10;
   logic [1:0] word_len = 2'b11;
   logic       fifo_req = 1'b0;
   logic [7:0] fifo_byte = '0;
   logic       fifo_ack;
   logic       tx_req;
   logic [7:0] tx_byte;
   logic       tx_ack = 1'b1;

   int n_chk = 0, n_bad = 0;
   logic [7:0] lg[$];
   logic [7:0] fq[$];
   bit   rnd_on = 0;
   int   fc_cnt = 0;
   logic [7:0] want_b = '0;
   bit   want_v = 0;
   logic [5:0] fifo_exp = '0;
   int   fifo_seen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fcinj_top u0 (
      .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .thr_cfg(thr_cfg),
      .mode_sel(mode_sel), .word_len(word_len),
      .xon_a(ON_A), .xon_b(ON_B), .xoff_a(OFF_A), .xoff_b(OFF_B),
      .fifo_req(fifo_req), .fifo_byte(fifo_byte), .fifo_ack(fifo_ack),
      .tx_req(tx_req), .tx_byte(tx_byte), .tx_ack(tx_ack)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_log(input string tag, input int n,
                             input logic [7:0] e0, input logic [7:0] e1,
                             input logic [7:0] e2, input logic [7:0] e3);
      logic [7:0] e[4];
      e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
      chk(lg.size() == n, {tag, " count"}, lg.size(), n);
      for (int i = 0; i < n && i < lg.size(); i++)
         chk(lg[i] == e[i], tag, lg[i], e[i]);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // logger of accepted bytes, sampled after the falling edge
   initial forever begin
      @(negedge clk); #2;
      if (rst_n && tx_req && tx_ack) begin
         lg.push_back(tx_byte);
         if (rnd_on) begin
            if (tx_byte >= 8'h40) begin
               fc_cnt++;
               if (want_v) begin
                  chk(tx_byte == want_b, "R4 pair order", tx_byte, want_b);
                  want_v = 0;
               end else if (tx_byte == OFF_A) begin
                  want_b = OFF_B; want_v = 1;
               end else if (tx_byte == ON_A) begin
                  want_b = ON_B; want_v = 1;
               end else begin
                  chk(0, "R4 lone second char", tx_byte, 0);
               end
            end else begin
               chk(!want_v, "R4 fifo byte inside pair", tx_byte, want_b);
               chk(tx_byte == {2'b00, fifo_exp}, "R10 fifo order", tx_byte, fifo_exp);
               fifo_exp++;
               fifo_seen++;
            end
         end
      end
   end

   // transmit FIFO model
   initial forever begin
      bit tk;
      @(negedge clk); #2;
      tk = fifo_ack;
      @(posedge clk); #1;
      if (tk && fq.size() > 0) void'(fq.pop_front());
      fifo_req  = (fq.size() > 0);
      fifo_byte = (fq.size() > 0) ? fq[0] : 8'h00;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      bit m_halt;
      int exp_fc;
      int pushed;
      logic [5:0] fnext;
      void'($urandom(32'd7411));

      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk(tx_req == 1'b0, "R1 reset tx_req", tx_req, 0);
      chk(fifo_ack == 1'b0, "R1 reset fifo_ack", fifo_ack, 0);
      rx_level = 7'd10;
      tick(5);
      chk(lg.size() == 0, "R1 quiet below mark", lg.size(), 0);

      rx_level = 7'd32;                       // equal to mark: nothing
      tick(5);
      chk(lg.size() == 0, "R2 level equal to mark", lg.size(), 0);

      rx_level = 7'd33;                       // crossing
      tick(1);
      chk(tx_req == 1'b0, "R11 one edge after crossing", tx_req, 0);
      tick(1);
      chk(tx_req == 1'b1, "R11 offered on second edge", tx_req, 1);
      chk(tx_byte == OFF_A, "R11 offered byte", tx_byte, OFF_A);
      tick(10);
      expect_log("R2 R5 single pause", 1, OFF_A, 0, 0, 0);

      rx_level = 7'd20;                       // inside band
      tick(10);
      chk(lg.size() == 1, "R3 hysteresis band", lg.size(), 1);
      rx_level = 7'd8;
      tick(5);
      expect_log("R3 resume", 2, OFF_A, ON_A, 0, 0);

      lg.delete();
      mode_sel = 2'b11;
      rx_level = 7'd40; tick(6);
      rx_level = 7'd0;  tick(6);
      expect_log("R4 both chars", 4, OFF_A, OFF_B, ON_A, ON_B);

      lg.delete();
      mode_sel = 2'b01;
      rx_level = 7'd40; tick(6);
      rx_level = 7'd0;  tick(6);
      expect_log("R4 second only", 2, OFF_B, ON_B, 0, 0);

      lg.delete();
      mode_sel = 2'b10;
      word_len = 2'b00; rx_level = 7'd40; tick(6);
      word_len = 2'b01; rx_level = 7'd0;  tick(6);
      word_len = 2'b10; rx_level = 7'd40; tick(6);
      rx_level = 7'd0;  tick(6);
      expect_log("R8 trimmed chars", 4, OFF_A & 8'h1F, ON_A & 8'h3F, OFF_A & 8'h7F, ON_A & 8'h7F);
      lg.delete();
      word_len = 2'b00;
      fq.push_back(8'hFF);
      tick(5);
      expect_log("R8 fifo byte untouched", 1, 8'hFF, 0, 0, 0);
      word_len = 2'b11;

      lg.delete();
      tx_ack = 1'b0;
      fq.push_back(8'h21); fq.push_back(8'h22);
      tick(3);
      chk(tx_req == 1'b1, "R7 offer up", tx_req, 1);
      chk(tx_byte == 8'h21, "R7 offered byte", tx_byte, 8'h21);
      rx_level = 7'd40;
      tick(4);
      chk(tx_byte == 8'h21, "R7 held during stall", tx_byte, 8'h21);
      chk(fifo_ack == 1'b0, "R7 no fifo take during stall", fifo_ack, 0);
      tx_ack = 1'b1;
      tick(6);
      expect_log("R6 pause beats fifo", 3, 8'h21, OFF_A, 8'h22, 0);
      rx_level = 7'd0;
      tick(6);

      lg.delete();
      mode_sel = 2'b00;
      rx_level = 7'd40; tick(6);
      rx_level = 7'd0;  tick(6);
      fq.push_back(8'h30);
      tick(5);
      expect_log("R9 injection off", 1, 8'h30, 0, 0, 0);

      // constrained random phase
      lg.delete();
      mode_sel = 2'b11;
      tick(3);
      m_halt = 0; exp_fc = 0; pushed = 0; fnext = '0;
      rnd_on = 1;
      for (int it = 0; it < 300; it++) begin
         int lv;
         int w;
         lv = $urandom_range(0, 64);
         rx_level = 7'(lv);
         if (!m_halt && lv > HI) begin
            m_halt = 1; exp_fc += 2;
         end else if (m_halt && lv <= LO) begin
            m_halt = 0; exp_fc += 2;
         end
         if ($urandom_range(0, 1) == 1) begin
            fq.push_back({2'b00, fnext});
            fnext++;
            pushed++;
         end
         w = 0;
         while (w < 3 || (fc_cnt != exp_fc && w < 300)) begin
            tx_ack = ($urandom_range(0, 3) != 0);
            tick(1);
            w++;
         end
         chk(fc_cnt == exp_fc, "R5 one sequence per change", fc_cnt, exp_fc);
      end
      tx_ack = 1'b1;
      tick(200);
      chk(fc_cnt == exp_fc, "R5 final char count", fc_cnt, exp_fc);
      chk(fifo_seen == pushed, "R10 all fifo bytes forwarded", fifo_seen, pushed);
      chk(!want_v, "R4 pair completed", want_v, 0);
      rnd_on = 0;

      finish_run();
   end

endmodule